// File: doc/BRIEF.md
# Helper-Thread Register Validity Tracker

This block keeps one trust bit per architectural register for a helper thread that pre-executes code ahead of the main thread. A set bit means the register holds a value that was either copied from the main thread when the helper was started or computed only from trusted values. At rename, each instruction's source bits are looked up. An instruction whose sources are all trusted runs normally. Any other instruction is turned into a no-op that uses no later pipeline resources, and its destinations become untrusted. Predicated instructions follow extra rules, so that a false or untrusted predicate never disturbs destination trust.

Two instructions are handled per cycle, and the second one sees the first one's destination updates in the same cycle. Control inputs do four things: clear the whole table when a new helper thread starts, mark live-in registers as trusted one at a time, clear a fixed range of scratch general registers before the postfix phase, and spill or fill single bits so that the table can be saved and restored together with register contents.

The table covers 128 general, 128 floating-point, 64 predicate and 8 branch registers.

Top module: `vbit_rename_track`

## Requirements
- R1: After reset, and on the edge after `start_clr` is high, every register reads as untrusted except predicate register 0.
- R2: A lane with `ren_valid` high, every enabled source trusted and its predicate register trusted drives `issue`=1 and `nop`=0 in the same cycle. A lane with `ren_valid` low drives both outputs low.
- R3: A lane with any enabled source untrusted drives `nop`=1 and `issue`=0. If its predicate is trusted and not known false, each enabled destination becomes untrusted at the next edge.
- R4: When all enabled sources are trusted and the predicate is trusted and not known false, each enabled destination becomes trusted at the next edge.
- R5: When the predicate register is trusted and `pred_known`=1 with `pred_val`=0, no destination bit changes.
- R6: When the predicate register itself is untrusted, no destination bit changes and the lane drives `nop`=1.
- R7: `livein_we` marks `livein_reg` as trusted at the next edge.
- R8: `temp_clr` makes general registers 32 to 47 untrusted at the next edge and leaves every other register unchanged.
- R9: Lane 1 reads lane 0's destination results of the same cycle. When both lanes write the same register, lane 1's value is kept.
- R10: `spill_rd_bit` returns the bit named by `spill_rd_reg` one cycle after `spill_rd_en`, as the table stood before that edge's update. `fill_we` writes `fill_bit` into `fill_reg`.
- R11: A register operand is 9 bits: bits [8:7] give the class (0 general, 1 floating-point, 2 predicate, 3 branch) and bits [6:0] give the index. Predicate operands use index bits [5:0] and branch operands use bits [2:0]; higher index bits are ignored. `pred_reg` is a 6-bit predicate index.
- R12: Predicate register 0 always reads as trusted, and writes to it have no effect.
- R13: Within one edge, updates take effect in this order, with later ones winning: live-in write, fill, lane 0, lane 1, scratch clear, full clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_clr | input | 1 | Clear all trust bits (new helper thread) |
| temp_clr | input | 1 | Clear the scratch general registers 32..47 |
| livein_we | input | 1 | Mark one live-in register as trusted |
| livein_reg | input | 9 | Live-in register operand |
| fill_we | input | 1 | Restore one trust bit |
| fill_reg | input | 9 | Register operand to restore |
| fill_bit | input | 1 | Restored bit value |
| ren_valid | input | 2 | Per-lane instruction present |
| src_en | input | 6 | Source enables, 3 per lane (lane l at [3l+2:3l]) |
| src_reg | input | 54 | Source operands, 9 bits each, lane-major |
| dst_en | input | 4 | Destination enables, 2 per lane |
| dst_reg | input | 36 | Destination operands, 9 bits each, lane-major |
| pred_reg | input | 12 | Predicate register index, 6 bits per lane |
| pred_known | input | 2 | Predicate value is known at rename |
| pred_val | input | 2 | Predicate value when known |
| issue | output | 2 | Lane executes normally |
| nop | output | 2 | Lane is squashed into a no-op |
| spill_rd_en | input | 1 | Request a spill read |
| spill_rd_reg | input | 9 | Register operand to spill |
| spill_rd_bit | output | 1 | Spilled bit, one cycle after the request |

## Verification
`issue` and `nop` depend only on the inputs and the table contents, so they are due in the cycle the instruction is presented. The bench compares them on the falling edge of that same cycle. Table updates appear after the next rising edge and can only be seen through the spill port, which answers one cycle after the request. The bench therefore records the expected bit when the request is presented and compares it on the following falling edge, using a behavioural model that is advanced once per rising edge.

// File: rtl/vbit_pkg.sv
package vbit_pkg;
  localparam int GR_N  = 128;
  localparam int FR_N  = 128;
  localparam int PR_N  = 64;
  localparam int BR_N  = 8;
  localparam int TOT   = GR_N + FR_N + PR_N + BR_N;
  localparam int FW    = $clog2(TOT);
  localparam int GR_IW = $clog2(GR_N);
  localparam int FR_IW = $clog2(FR_N);
  localparam int PR_IW = $clog2(PR_N);
  localparam int BR_IW = $clog2(BR_N);
  localparam int IW    = GR_IW;
  localparam int OPW   = 2 + IW;
  localparam int PW    = PR_IW;
  localparam int FR_BASE = GR_N;
  localparam int PR_BASE = GR_N + FR_N;
  localparam int BR_BASE = GR_N + FR_N + PR_N;
  localparam int PR0_FLAT = PR_BASE;

  typedef enum logic [1:0] {CL_GR = 2'd0, CL_FR = 2'd1, CL_PR = 2'd2, CL_BR = 2'd3} reg_class_e;

  // Map a class/index operand onto one flat table position.
  function automatic logic [FW-1:0] flat_of(input logic [OPW-1:0] op);
    reg_class_e cls;
    cls = reg_class_e'(op[OPW-1 -: 2]);
    case (cls)
      CL_GR:   return FW'(op[GR_IW-1:0]);
      CL_FR:   return FW'(FR_BASE) + FW'(op[FR_IW-1:0]);
      CL_PR:   return FW'(PR_BASE) + FW'(op[PR_IW-1:0]);
      default: return FW'(BR_BASE) + FW'(op[BR_IW-1:0]);
    endcase
  endfunction

  // Destination writes are held when the predicate is untrusted or known false.
  function automatic logic dest_hold(input logic pbit, input logic known, input logic val);
    return !pbit || (known && !val);
  endfunction
endpackage

// File: rtl/vbit_opdec.sv
module vbit_opdec
  import vbit_pkg::*;
(
  input  logic [OPW-1:0] op,
  output logic [FW-1:0]  flat
);
  assign flat = flat_of(op);
endmodule

// File: rtl/vbit_table.sv
module vbit_table
  import vbit_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int DSTS      = 2,
  parameter int TEMP_BASE = 32,
  parameter int TEMP_CNT  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_clr,
  input  logic                          temp_clr,
  input  logic                          livein_we,
  input  logic [FW-1:0]                 livein_flat,
  input  logic                          fill_we,
  input  logic [FW-1:0]                 fill_flat,
  input  logic                          fill_bit,
  input  logic [LANES-1:0][DSTS-1:0]    upd_en,
  input  logic [FW-1:0]                 upd_flat [LANES][DSTS],
  input  logic [LANES-1:0]              upd_val,
  input  logic                          spill_rd_en,
  input  logic [FW-1:0]                 spill_rd_flat,
  output logic                          spill_rd_bit,
  output logic [TOT-1:0]                vbits
);
  logic [TOT-1:0] store;
  logic [TOT-1:0] nxt;
  logic           lane_wr_any;

  assign lane_wr_any = |upd_en;

  // predicate register 0 is hard-wired trusted (R12)
  always_comb begin
    vbits = store;
    vbits[PR0_FLAT] = 1'b1;
  end

  // write ordering: live-in, fill, lane 0, lane 1, scratch clear, full clear (R13)
  always_comb begin
    nxt = store;
    if (livein_we) nxt[livein_flat] = 1'b1;
    if (fill_we)   nxt[fill_flat]   = fill_bit;
    for (int l = 0; l < LANES; l++) begin
      for (int d = 0; d < DSTS; d++) begin
        if (upd_en[l][d]) nxt[upd_flat[l][d]] = upd_val[l];
      end
    end
    if (temp_clr) nxt[TEMP_BASE +: TEMP_CNT] = '0;
    if (start_clr) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store        <= '0;
      spill_rd_bit <= 1'b0;
    end else begin
      store <= nxt;
      if (spill_rd_en) spill_rd_bit <= vbits[spill_rd_flat];
    end
  end

  // R1
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> (store == '0));

  // R8
  temp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_clr && !start_clr) |=> (store[TEMP_BASE +: TEMP_CNT] == '0));

  // R7
  livein_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (livein_we && !start_clr && !temp_clr && !fill_we && !lane_wr_any)
      |=> store[$past(livein_flat)]);

  // R10
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !start_clr && !temp_clr && !lane_wr_any)
      |=> (store[$past(fill_flat)] == $past(fill_bit)));
endmodule

// File: rtl/vbit_rename_track.sv
module vbit_rename_track
  import vbit_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int SRCS      = 3,
  parameter int DSTS      = 2,
  parameter int TEMP_BASE = 32,
  parameter int TEMP_CNT  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_clr,
  input  logic                      temp_clr,
  input  logic                      livein_we,
  input  logic [OPW-1:0]            livein_reg,
  input  logic                      fill_we,
  input  logic [OPW-1:0]            fill_reg,
  input  logic                      fill_bit,
  input  logic [LANES-1:0]          ren_valid,
  input  logic [LANES*SRCS-1:0]     src_en,
  input  logic [LANES*SRCS*OPW-1:0] src_reg,
  input  logic [LANES*DSTS-1:0]     dst_en,
  input  logic [LANES*DSTS*OPW-1:0] dst_reg,
  input  logic [LANES*PW-1:0]       pred_reg,
  input  logic [LANES-1:0]          pred_known,
  input  logic [LANES-1:0]          pred_val,
  output logic [LANES-1:0]          issue,
  output logic [LANES-1:0]          nop,
  input  logic                      spill_rd_en,
  input  logic [OPW-1:0]            spill_rd_reg,
  output logic                      spill_rd_bit
);
  logic [FW-1:0] src_f  [LANES][SRCS];
  logic [FW-1:0] dst_f  [LANES][DSTS];
  logic [FW-1:0] pred_f [LANES];
  logic [FW-1:0] livein_f, fill_f, spill_f;

  logic [TOT-1:0]               vbits;
  logic [LANES-1:0][DSTS-1:0]   upd_en;
  logic [LANES-1:0]             upd_val;
  logic [LANES-1:0]             src_ok_w;
  logic [LANES-1:0]             pred_bit_w;
  logic [LANES-1:0]             hold_w;

  // operand decoders (R11)
  for (genvar l = 0; l < LANES; l++) begin : g_dec
    for (genvar s = 0; s < SRCS; s++) begin : g_src
      vbit_opdec u_src (.op(src_reg[(l*SRCS+s)*OPW +: OPW]), .flat(src_f[l][s]));
    end
    for (genvar d = 0; d < DSTS; d++) begin : g_dst
      vbit_opdec u_dst (.op(dst_reg[(l*DSTS+d)*OPW +: OPW]), .flat(dst_f[l][d]));
    end
    vbit_opdec u_pred (
      .op({CL_PR, {(IW-PW){1'b0}}, pred_reg[l*PW +: PW]}),
      .flat(pred_f[l])
    );
  end
  vbit_opdec u_livein (.op(livein_reg),   .flat(livein_f));
  vbit_opdec u_fill   (.op(fill_reg),     .flat(fill_f));
  vbit_opdec u_spill  (.op(spill_rd_reg), .flat(spill_f));

  // Lanes are evaluated in order on a working copy so later lanes see
  // earlier lanes' destination results (R9).
  always_comb begin
    logic [TOT-1:0] work;
    logic ok;
    work = vbits;
    for (int l = 0; l < LANES; l++) begin
      ok = 1'b1;
      for (int s = 0; s < SRCS; s++) begin
        if (src_en[l*SRCS+s] && !work[src_f[l][s]]) ok = 1'b0;
      end
      src_ok_w[l]   = ok;
      pred_bit_w[l] = work[pred_f[l]];
      hold_w[l]     = dest_hold(pred_bit_w[l], pred_known[l], pred_val[l]);
      issue[l]      = ren_valid[l] && ok && pred_bit_w[l];
      nop[l]        = ren_valid[l] && !(ok && pred_bit_w[l]);
      upd_val[l]    = ok;
      for (int d = 0; d < DSTS; d++) begin
        upd_en[l][d] = ren_valid[l] && dst_en[l*DSTS+d] && !hold_w[l];
        if (upd_en[l][d]) work[dst_f[l][d]] = ok;
      end
      work[PR0_FLAT] = 1'b1;
    end
  end

  vbit_table #(
    .LANES(LANES), .DSTS(DSTS), .TEMP_BASE(TEMP_BASE), .TEMP_CNT(TEMP_CNT)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .start_clr(start_clr), .temp_clr(temp_clr),
    .livein_we(livein_we), .livein_flat(livein_f),
    .fill_we(fill_we), .fill_flat(fill_f), .fill_bit(fill_bit),
    .upd_en(upd_en), .upd_flat(dst_f), .upd_val(upd_val),
    .spill_rd_en(spill_rd_en), .spill_rd_flat(spill_f),
    .spill_rd_bit(spill_rd_bit), .vbits(vbits)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R2
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ren_valid[l] |-> (!issue[l] && !nop[l]));
    // R3
    src_untrusted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[l] && !src_ok_w[l]) |-> (nop[l] && !issue[l]));
    // R6
    pred_untrusted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[l] && !pred_bit_w[l]) |-> (nop[l] && (upd_en[l] == '0)));
    // R5
    pred_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[l] && pred_known[l] && !pred_val[l]) |-> (upd_en[l] == '0));
  end
endmodule

// File: tb/vbit_rename_track_tb.sv
module vbit_rename_track_tb_top;
  import vbit_pkg::*;

  localparam int L = 2, S = 3, D = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic start_clr, temp_clr, livein_we, fill_we, fill_bit, spill_rd_en;
  logic [8:0] livein_reg, fill_reg, spill_rd_reg;
  logic [L-1:0] ren_valid, pred_known, pred_val, issue, nop;
  logic [L*S-1:0] src_en;
  logic [L*S*9-1:0] src_reg;
  logic [L*D-1:0] dst_en;
  logic [L*D*9-1:0] dst_reg;
  logic [L*6-1:0] pred_reg;
  logic spill_rd_bit;

  always #5 clk = ~clk;

  vbit_rename_track dut_i (
    .clk(clk), .rst_n(rst_n), .start_clr(start_clr), .temp_clr(temp_clr),
    .livein_we(livein_we), .livein_reg(livein_reg),
    .fill_we(fill_we), .fill_reg(fill_reg), .fill_bit(fill_bit),
    .ren_valid(ren_valid), .src_en(src_en), .src_reg(src_reg),
    .dst_en(dst_en), .dst_reg(dst_reg), .pred_reg(pred_reg),
    .pred_known(pred_known), .pred_val(pred_val),
    .issue(issue), .nop(nop),
    .spill_rd_en(spill_rd_en), .spill_rd_reg(spill_rd_reg), .spill_rd_bit(spill_rd_bit)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: 328 trust bits, flat order general, float, predicate, branch.
  bit mdl [0:327];
  bit nxt [0:327];
  bit w   [0:327];

  function automatic int fl(input logic [8:0] op);
    case (op[8:7])
      2'd0: return int'(op[6:0]);
      2'd1: return 128 + int'(op[6:0]);
      2'd2: return 256 + int'(op[5:0]);
      default: return 320 + int'(op[2:0]);
    endcase
  endfunction

  function automatic bit rd_w(input int f);
    return (f == 256) ? 1'b1 : w[f];
  endfunction
  function automatic bit rd_m(input int f);
    return (f == 256) ? 1'b1 : mdl[f];
  endfunction

  bit sp_pend = 0, sp_exp = 0;
  string sp_req = "R10";

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sp_pend) chk(spill_rd_bit == sp_exp, sp_req, "spill bit", spill_rd_bit, sp_exp);
      sp_pend = 0;
      if (spill_rd_en) begin
        sp_pend = 1;
        sp_exp  = rd_m(fl(spill_rd_reg));
        sp_req  = cur_req;
      end
      for (int i = 0; i < 328; i++) begin w[i] = mdl[i]; nxt[i] = mdl[i]; end
      if (livein_we) nxt[fl(livein_reg)] = 1;
      if (fill_we) nxt[fl(fill_reg)] = fill_bit;
      for (int l = 0; l < L; l++) begin
        bit ok, pb, ei, en;
        string tag;
        ok = 1;
        for (int s = 0; s < S; s++)
          if (src_en[l*S+s] && !rd_w(fl(src_reg[(l*S+s)*9 +: 9]))) ok = 0;
        pb = rd_w(fl({2'd2, 1'b0, pred_reg[l*6 +: 6]}));
        ei = ren_valid[l] && ok && pb;
        en = ren_valid[l] && !(ok && pb);
        if (!ren_valid[l]) tag = "R2";
        else if (!pb) tag = "R6";
        else if (ok) tag = "R2";
        else tag = "R3";
        chk(issue[l] == ei, tag, $sformatf("lane%0d issue", l), issue[l], ei);
        chk(nop[l] == en, tag, $sformatf("lane%0d nop", l), nop[l], en);
        if (ren_valid[l] && pb && !(pred_known[l] && !pred_val[l]))
          for (int d = 0; d < D; d++)
            if (dst_en[l*D+d]) begin
              w[fl(dst_reg[(l*D+d)*9 +: 9])]   = ok;
              nxt[fl(dst_reg[(l*D+d)*9 +: 9])] = ok;
            end
      end
      if (temp_clr) for (int i = 32; i < 48; i++) nxt[i] = 0;
      if (start_clr) for (int i = 0; i < 328; i++) nxt[i] = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 328; i++) mdl[i] <= 0;
    else if (!done) for (int i = 0; i < 328; i++) mdl[i] <= nxt[i];
  end

  function automatic logic [8:0] gr(input int i); return {2'd0, 7'(i)}; endfunction
  function automatic logic [8:0] frg(input int i); return {2'd1, 7'(i)}; endfunction
  function automatic logic [8:0] prg(input int i); return {2'd2, 7'(i)}; endfunction
  function automatic logic [8:0] brg(input int i); return {2'd3, 7'(i)}; endfunction

  task automatic clear_in();
    start_clr = 0; temp_clr = 0; livein_we = 0; fill_we = 0; fill_bit = 0;
    spill_rd_en = 0; livein_reg = 0; fill_reg = 0; spill_rd_reg = 0;
    ren_valid = 0; src_en = 0; src_reg = 0; dst_en = 0; dst_reg = 0;
    pred_reg = 0; pred_known = 0; pred_val = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clear_in();
  endtask

  task automatic lane(input int l, input logic [8:0] s0, s1, s2, input logic [2:0] se,
                      input logic [8:0] d0, d1, input logic [1:0] de,
                      input logic [5:0] p, input logic pk, pv);
    ren_valid[l] = 1;
    src_reg[(l*S+0)*9 +: 9] = s0; src_reg[(l*S+1)*9 +: 9] = s1; src_reg[(l*S+2)*9 +: 9] = s2;
    src_en[l*S +: S] = se;
    dst_reg[(l*D+0)*9 +: 9] = d0; dst_reg[(l*D+1)*9 +: 9] = d1;
    dst_en[l*D +: D] = de;
    pred_reg[l*6 +: 6] = p; pred_known[l] = pk; pred_val[l] = pv;
  endtask

  task automatic rd(input logic [8:0] op);
    spill_rd_en = 1; spill_rd_reg = op; tick(); tick();
  endtask

  task automatic lin(input logic [8:0] op);
    livein_we = 1; livein_reg = op; tick();
  endtask

  function automatic logic [8:0] rop();
    logic [6:0] ix;
    ix = ($urandom % 2 == 0) ? 7'($urandom % 8) : 7'(32 + $urandom % 4);
    return {2'($urandom % 4), ix};
  endfunction

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    cur_req = "R1";
    rd(gr(5)); rd(frg(3)); rd(brg(7));
    cur_req = "R12";
    rd(prg(0));

    cur_req = "R7";
    lin(gr(1)); lin(gr(2)); lin(frg(0)); lin(prg(1));
    rd(gr(1)); rd(frg(0)); rd(prg(1)); rd(gr(3));

    cur_req = "R4";
    lane(0, gr(1), gr(2), 0, 3'b011, gr(10), frg(9), 2'b11, 0, 0, 0); tick();
    rd(gr(10)); rd(frg(9));

    cur_req = "R3";
    lane(0, gr(1), gr(3), 0, 3'b011, gr(10), 0, 2'b01, 0, 0, 0); tick();
    rd(gr(10)); rd(frg(9));

    cur_req = "R5";
    lin(prg(2));
    lane(0, gr(1), 0, 0, 3'b001, gr(11), 0, 2'b01, 6'd2, 1, 0); tick();
    rd(gr(11));
    lane(0, gr(1), 0, 0, 3'b001, gr(11), 0, 2'b01, 6'd2, 1, 1); tick();
    lane(0, gr(3), 0, 0, 3'b001, gr(11), 0, 2'b01, 6'd2, 1, 0); tick();
    rd(gr(11));

    cur_req = "R6";
    lane(0, gr(1), 0, 0, 3'b001, gr(11), gr(12), 2'b11, 6'd5, 1, 1); tick();
    rd(gr(11)); rd(gr(12));
    lane(1, gr(3), 0, 0, 3'b001, gr(11), 0, 2'b01, 6'd5, 0, 0); tick();
    rd(gr(11));

    cur_req = "R9";
    lane(0, gr(1), 0, 0, 3'b001, gr(20), 0, 2'b01, 0, 0, 0);
    lane(1, gr(20), 0, 0, 3'b001, gr(21), 0, 2'b01, 0, 0, 0); tick();
    rd(gr(21));
    lane(0, gr(3), 0, 0, 3'b001, gr(20), 0, 2'b01, 0, 0, 0);
    lane(1, gr(20), 0, 0, 3'b001, gr(23), 0, 2'b01, 0, 0, 0); tick();
    rd(gr(20));
    lane(0, gr(1), 0, 0, 3'b001, gr(22), 0, 2'b01, 0, 0, 0);
    lane(1, gr(3), 0, 0, 3'b001, gr(22), 0, 2'b01, 0, 0, 0); tick();
    rd(gr(22));
    lin(prg(9));
    lane(0, gr(3), 0, 0, 3'b001, prg(9), 0, 2'b01, 0, 0, 0);
    lane(1, gr(1), 0, 0, 3'b001, gr(24), 0, 2'b01, 6'd9, 0, 0); tick();
    rd(gr(24));

    cur_req = "R8";
    lin(gr(32)); lin(gr(47)); lin(gr(48)); lin(gr(31));
    temp_clr = 1; tick();
    rd(gr(32)); rd(gr(47)); rd(gr(48)); rd(gr(31));

    cur_req = "R10";
    fill_we = 1; fill_reg = gr(60); fill_bit = 1; tick();
    fill_we = 1; fill_reg = frg(100); fill_bit = 1; tick();
    rd(gr(60)); rd(frg(100));
    fill_we = 1; fill_reg = gr(60); fill_bit = 0; spill_rd_en = 1; spill_rd_reg = gr(60); tick();
    tick();
    rd(gr(60));

    cur_req = "R11";
    lin({2'd3, 7'h0A}); rd(brg(2)); rd(brg(3));
    lin({2'd2, 7'h41}); lin({2'd2, 7'h45}); rd(prg(5)); rd(gr(69));

    cur_req = "R12";
    lane(0, gr(3), 0, 0, 3'b001, prg(0), 0, 2'b01, 0, 0, 0); tick();
    rd(prg(0));
    lane(0, prg(0), 0, 0, 3'b001, gr(25), 0, 2'b01, 0, 0, 0); tick();
    rd(gr(25));

    cur_req = "R13";
    livein_we = 1; livein_reg = gr(70); fill_we = 1; fill_reg = gr(70); fill_bit = 0; tick();
    rd(gr(70));
    lane(0, gr(1), 0, 0, 3'b001, gr(33), 0, 2'b01, 0, 0, 0); temp_clr = 1; tick();
    rd(gr(33));
    lin(gr(5));
    lane(0, gr(1), 0, 0, 3'b001, gr(5), 0, 2'b01, 0, 0, 0);
    lane(1, gr(3), 0, 0, 3'b001, gr(5), 0, 2'b01, 0, 0, 0); tick();
    rd(gr(5));
    livein_we = 1; livein_reg = gr(71); start_clr = 1; tick();
    rd(gr(71));

    cur_req = "R1";
    start_clr = 1; tick();
    rd(gr(1)); rd(frg(0)); rd(prg(2)); rd(prg(0));

    cur_req = "R4";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 4 == 0) begin livein_we = 1; livein_reg = rop(); end
      if ($urandom % 8 == 0) begin fill_we = 1; fill_reg = rop(); fill_bit = 1'($urandom); end
      if ($urandom % 64 == 0) temp_clr = 1;
      if ($urandom % 300 == 0) start_clr = 1;
      spill_rd_en = 1; spill_rd_reg = rop();
      for (int l = 0; l < L; l++)
        if ($urandom % 4 != 0)
          lane(l, rop(), rop(), rop(), 3'($urandom), rop(), rop(), 2'($urandom),
               6'($urandom % 4), 1'($urandom), 1'($urandom));
      tick();
    end
    tick(); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule